// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two 64-bit operands either as a single full-width word or as a set of independent packed lanes of 8, 16 or 32 bits, applying the same operation to every lane at once. It serves narrow media data such as 8-bit colour and transparency channels. Carries never leave their lane. A control input picks the lane width, another picks signed or unsigned interpretation, a third picks addition or subtraction, and a mode bit picks wrap-around or saturating arithmetic.

In saturating mode each lane whose exact result does not fit is clamped to the nearest representable limit of its type, and a per-lane flag reports that clamping took place. The arithmetic is combinational; a parameter adds one output register stage, which is on by default.

Top module: `simd_sat_adder`

## Requirements
- R1: `size_i` selects the lane width: 0 gives 8 bits (8 lanes), 1 gives 16 bits (4 lanes), 2 gives 32 bits (2 lanes), 3 gives 64 bits (1 lane). Lane i occupies bits [i*w+w-1 : i*w], and no carry or borrow passes from one lane into the next.
- R2: With `sub_i`=0 each lane computes a+b; with `sub_i`=1 each lane computes a-b. In 64-bit wrap mode the result equals the 64-bit sum or difference.
- R3: With `sat_i`=0 each lane holds the low w bits of its exact result and every bit of `sat_o` is 0.
- R4: With `sat_i`=1 and `sgn_i`=1, a lane whose exact result exceeds 2^(w-1)-1 becomes 2^(w-1)-1.
- R5: With `sat_i`=1 and `sgn_i`=1, a lane whose exact result is below -2^(w-1) becomes -2^(w-1).
- R6: With `sat_i`=1, `sgn_i`=0 and `sub_i`=0, a lane whose sum exceeds 2^w-1 becomes 2^w-1 (all ones).
- R7: With `sat_i`=1, `sgn_i`=0 and `sub_i`=1, a lane where b is greater than a becomes 0.
- R8: `sat_o` bit i is 1 exactly when lane i was clamped; bits at or above the lane count are 0. A lane whose exact result fits is passed through unchanged.
- R9: With the output register enabled, `res_o` and `sat_o` show the result of the inputs present at the previous rising edge of `clk_i`; while `rst_ni` is low both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| size_i | input | 2 | Lane width code |
| sgn_i | input | 1 | 1: lanes are signed, 0: unsigned |
| sat_i | input | 1 | 1: saturating, 0: wrap-around |
| sub_i | input | 1 | 1: subtract b from a, 0: add |
| res_o | output | 64 | Packed result |
| sat_o | output | 8 | Per-lane clamp flags, bit i for lane i |

## Verification
The hard case is a lane that clamps in the same cycle as a neighbouring lane that must stay exact, with the clamping lane's carry or borrow ready to spill across the boundary. The bench provokes it with operand patterns such as an all-ones lane plus one next to a zero lane, in each lane width, signed and unsigned, adding and subtracting. It judges the neighbour's value bit-exact against a per-lane model and requires the flag to mark only the clamped lane.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    CL_NONE,
    CL_ALL1,
    CL_ALL0,
    CL_SMAX,
    CL_SMIN
  } clamp_e;
endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] bx;
  logic [W:0]   s;

  assign bx     = sub_i ? ~b_i : b_i;
  assign s      = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cin_i};
  assign sum_o  = s[W-1:0];
  assign cout_o = s[W];
  // signed overflow, meaningful only on a lane's top segment
  assign ovf_o  = (a_i[W-1] == bx[W-1]) && (s[W-1] != a_i[W-1]);
endmodule

// File: rtl/simd_sat_ctl.sv
module simd_sat_ctl
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum_i,
  input  logic         is_top_i,
  input  logic         sgn_i,
  input  logic         sat_i,
  input  logic         sub_i,
  input  logic         lane_ovf_i,
  input  logic         lane_cout_i,
  input  logic         lane_amsb_i,
  output logic [W-1:0] res_o,
  output logic         clamp_o
);
  clamp_e kind;

  always_comb begin
    kind = CL_NONE;
    if (sat_i) begin
      if (sgn_i) begin
        if (lane_ovf_i) kind = lane_amsb_i ? CL_SMIN : CL_SMAX;
      end else if (sub_i ? !lane_cout_i : lane_cout_i) begin
        kind = sub_i ? CL_ALL0 : CL_ALL1;
      end
    end
  end

  always_comb begin
    unique case (kind)
      CL_ALL1: res_o = '1;
      CL_ALL0: res_o = '0;
      CL_SMAX: res_o = is_top_i ? {1'b0, {(W-1){1'b1}}} : '1;
      CL_SMIN: res_o = is_top_i ? {1'b1, {(W-1){1'b0}}} : '0;
      default: res_o = sum_i;
    endcase
  end

  assign clamp_o = (kind != CL_NONE);
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int DATA_W  = 64,
  parameter int SEG_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [DATA_W-1:0]                     a_i,
  input  logic [DATA_W-1:0]                     b_i,
  input  logic [$clog2($clog2(DATA_W/SEG_W)+1)-1:0] size_i,
  input  logic                                  sgn_i,
  input  logic                                  sat_i,
  input  logic                                  sub_i,
  output logic [DATA_W-1:0]                     res_o,
  output logic [DATA_W/SEG_W-1:0]               sat_o
);
  localparam int NSEG = DATA_W / SEG_W;
  localparam int LG   = $clog2(NSEG);

  logic [NSEG-1:0]   cin, cout, ovf, clamp;
  logic [NSEG-1:0]   lane_ovf, lane_cout, lane_amsb, is_top, lane_start;
  logic [SEG_W-1:0]  sum [NSEG];
  logic [DATA_W-1:0] res_c;
  logic [NSEG-1:0]   flag_c;
  int                sz_eff, lsegs;

  always_comb begin
    sz_eff = (int'(size_i) > LG) ? LG : int'(size_i);
    lsegs  = 1 << sz_eff;
    for (int k = 0; k < NSEG; k++) begin
      int t;
      t             = k | (lsegs - 1);
      lane_start[k] = ((k & (lsegs - 1)) == 0);
      is_top[k]     = (k == t);
      lane_ovf[k]   = ovf[t];
      lane_cout[k]  = cout[t];
      lane_amsb[k]  = a_i[t*SEG_W + SEG_W - 1];
    end
  end

  // carry chain cut at every lane start
  always_comb begin
    for (int k = 0; k < NSEG; k++)
      cin[k] = (k == 0 || lane_start[k]) ? sub_i : cout[(k == 0) ? 0 : k-1];
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    simd_seg_add #(.W(SEG_W)) i_add (
      .a_i    (a_i[k*SEG_W +: SEG_W]),
      .b_i    (b_i[k*SEG_W +: SEG_W]),
      .sub_i  (sub_i),
      .cin_i  (cin[k]),
      .sum_o  (sum[k]),
      .cout_o (cout[k]),
      .ovf_o  (ovf[k])
    );

    simd_sat_ctl #(.W(SEG_W)) i_sat (
      .sum_i       (sum[k]),
      .is_top_i    (is_top[k]),
      .sgn_i       (sgn_i),
      .sat_i       (sat_i),
      .sub_i       (sub_i),
      .lane_ovf_i  (lane_ovf[k]),
      .lane_cout_i (lane_cout[k]),
      .lane_amsb_i (lane_amsb[k]),
      .res_o       (res_c[k*SEG_W +: SEG_W]),
      .clamp_o     (clamp[k])
    );

    // R1: narrowest lanes stay isolated in wrap mode
    assert_seg_isolated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (size_i == 0 && !sat_i) |->
        res_c[k*SEG_W +: SEG_W] == (sub_i ? a_i[k*SEG_W +: SEG_W] - b_i[k*SEG_W +: SEG_W]
                                          : a_i[k*SEG_W +: SEG_W] + b_i[k*SEG_W +: SEG_W]));
  end

  always_comb begin
    flag_c = '0;
    for (int k = 0; k < NSEG; k++)
      if (is_top[k]) flag_c[k >> sz_eff] = clamp[k];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o <= '0;
        sat_o <= '0;
      end else begin
        res_o <= res_c;
        sat_o <= flag_c;
      end
    end

    assert_out_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (res_o == $past(res_c)) && (sat_o == $past(flag_c)));
  end else begin : g_comb
    assign res_o = res_c;
    assign sat_o = flag_c;
  end

  assert_wrap_no_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sat_i |-> (flag_c == '0));

  assert_flags_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_c >> (NSEG >> sz_eff)) == '0);

  assert_full_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sz_eff == LG && !sat_i) |-> (res_c == (sub_i ? a_i - b_i : a_i + b_i)));

  assert_uns_add_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_i && !sgn_i && !sub_i && flag_c[0]) |-> (res_c[SEG_W-1:0] == '1));

  assert_uns_sub_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_i && !sgn_i && sub_i && flag_c[0]) |-> (res_c[SEG_W-1:0] == '0));

  assert_no_flag_no_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_c[0] == 1'b0) |-> (res_c[SEG_W-1:0] == sum[0]));
endmodule

// File: tb/test_simd_sat_adder.sv
module test_simd_sat_adder;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [1:0]  size_i = '0;
  logic        sgn_i = 1'b0, sat_i = 1'b0, sub_i = 1'b0;
  logic [63:0] res_o;
  logic [7:0]  sat_o;
  int          n_checks = 0;
  int          n_errs = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  simd_sat_adder i_simd_sat_adder (
    .clk_i, .rst_ni, .a_i, .b_i, .size_i, .sgn_i, .sat_i, .sub_i, .res_o, .sat_o
  );

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] sz, input logic sg, input logic st,
                                input logic sb, output logic [63:0] r, output logic [7:0] f);
    int w, n;
    logic signed [66:0] x, y, e, one, smax, smin, umax;
    w = 8 << sz; n = 64 / w; r = '0; f = '0; one = 67'sd1;
    smax = (one <<< (w-1)) - one; smin = -(one <<< (w-1)); umax = (one <<< w) - one;
    for (int i = 0; i < n; i++) begin
      x = '0; y = '0;
      for (int j = 0; j < w; j++) begin x[j] = a[i*w+j]; y[j] = b[i*w+j]; end
      if (sg) for (int j = w; j < 67; j++) begin x[j] = x[w-1]; y[j] = y[w-1]; end
      e = sb ? x - y : x + y;
      if (st) begin
        if (sg) begin
          if (e > smax) begin e = smax; f[i] = 1'b1; end
          else if (e < smin) begin e = smin; f[i] = 1'b1; end
        end else begin
          if (e > umax) begin e = umax; f[i] = 1'b1; end
          else if (e < 0) begin e = '0; f[i] = 1'b1; end
        end
      end
      for (int j = 0; j < w; j++) r[i*w+j] = e[j];
    end
  endfunction

  task automatic check(input string req, input logic [63:0] er, input logic [7:0] ef);
    n_checks++;
    if (res_o !== er || sat_o !== ef) begin
      n_errs++;
      $display("FAIL %s: res=%h sat=%b expected res=%h sat=%b", req, res_o, sat_o, er, ef);
    end
  endtask

  // drive at a falling edge, output registered at the next rising edge, sample at the falling edge after
  task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                     input logic [1:0] sz, input logic sg, input logic st, input logic sb);
    logic [63:0] er;
    logic [7:0]  ef;
    @(negedge clk_i);
    a_i = a; b_i = b; size_i = sz; sgn_i = sg; sat_i = st; sub_i = sb;
    model(a, b, sz, sg, st, sb, er, ef);
    @(negedge clk_i);
    check(req, er, ef);
  endtask

  task automatic test_reset;
    a_i = '1; b_i = '1; sat_i = 1'b1;
    #(CLK_P*3);
    check("R9 reset", 64'h0, 8'h0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic test_wrap;
    run("R1 R3 wrap 8b lanes", 64'hFF80_7F01_FF00_8080, 64'h0180_0101_01FF_8080, 2'd0, 1'b0, 1'b0, 1'b0);
    run("R1 R3 wrap 16b lanes", 64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001, 2'd1, 1'b1, 1'b0, 1'b0);
    run("R2 R3 wrap 32b sub", 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0002, 2'd2, 1'b0, 1'b0, 1'b1);
    run("R2 wrap 64b add", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 1'b0, 1'b0, 1'b0);
    run("R2 wrap 64b sub", 64'h1, 64'h2, 2'd3, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic test_signed;
    run("R4 signed 8b pos clamp", 64'h7F7F_7F7F_0102_0304, 64'h0101_7F01_0101_0101, 2'd0, 1'b1, 1'b1, 1'b0);
    run("R5 signed 8b neg clamp", 64'h8080_8080_8080_8080, 64'h0180_FF01_0000_7F00, 2'd0, 1'b1, 1'b1, 1'b1);
    run("R4 signed 16b sub clamp", 64'h7FFF_0000_1234_7FFF, 64'hFFFF_0001_1234_8000, 2'd1, 1'b1, 1'b1, 1'b1);
    run("R5 signed 32b clamp", 64'h8000_0000_4000_0000, 64'h8000_0000_4000_0000, 2'd2, 1'b1, 1'b1, 1'b0);
    run("R4 signed 64b clamp", 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic test_unsigned;
    run("R6 unsigned 8b add clamp", 64'hFF10_80FF_0000_F0F0, 64'h01F0_8001_0000_0F11, 2'd0, 1'b0, 1'b1, 1'b0);
    run("R7 unsigned 8b sub clamp", 64'h0010_8000_0500_F0F0, 64'h0111_7F01_0500_F0F1, 2'd0, 1'b0, 1'b1, 1'b1);
    run("R6 unsigned 32b add clamp", 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 2'd2, 1'b0, 1'b1, 1'b0);
    run("R7 unsigned 64b sub clamp", 64'h5, 64'h6, 2'd3, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic test_boundary;
    // clamping lane next to a lane that must stay exact
    run("R8 R1 16b clamp beside exact", 64'h0000_0000_1111_FFFF, 64'h0000_0000_2222_0001, 2'd1, 1'b0, 1'b1, 1'b0);
    run("R8 R1 16b borrow beside exact", 64'h0005_0000_0000_0000, 64'h0002_0001_0000_0000, 2'd1, 1'b0, 1'b1, 1'b1);
    run("R8 R1 8b signed mixed", 64'h7F00_807F_0000_7F01, 64'h7F00_8001_0000_0101, 2'd0, 1'b1, 1'b1, 1'b0);
    run("R8 no clamp exact", 64'h1020_3040_5060_7000, 64'h0102_0304_0506_0708, 2'd0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic test_sweep;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      if (i % 4 == 0) b = ~a;
      run("R1 R2 R4 R5 R6 R7 R8 sweep", a, b, 2'(i % 4), 1'((i/4) % 2), 1'((i/8) % 2), 1'((i/16) % 2));
    end
  endtask

  initial begin
    #(CLK_P*200000);
    n_checks++; n_errs++;
    $display("FAIL watchdog: res=%h sat=%b expected completion", res_o, sat_o);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    test_reset();
    test_wrap();
    test_signed();
    test_unsigned();
    test_boundary();
    test_sweep();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule